// File: doc/BRIEF.md
# Decimated Output Settling Controller

This block sets the output-data timing of a sigma-delta decimation path and decides which conversion results leave the filter after a restart. It runs on the modulator clock. A 3-bit code selects the oversampling ratio, and the output data period equals that ratio in modulator cycles. A single-cycle strobe marks each result that is delivered.

The digital filter needs 68 conversions to settle after a restart. A synchronization pulse restarts the period timing and the settling count. A mode bit chooses how the early results are handled. In settled mode they are withheld, so the first result delivered is already clean. In unsettled mode they are delivered, and each one is tagged as not settled. A separate step-detect pulse marks the conversions that follow an asynchronous input step as partially settled.

Each delivered result carries a 2-bit tag:

| Code | Meaning |
|---|---|
| 2'b00 | settled |
| 2'b01 | unsettled after a sync |
| 2'b10 | partially settled after a step |

The ratio code and the mode are sampled only on a sync pulse.

Top module: `dec_settle_ctrl`

## Requirements
- R1: The ratio code c maps to a data period of 32·2^c modulator cycles, so code 0 gives 32 and code 7 gives 4096. Consecutive strobes within one sync window are exactly one period apart.
- R2: `drdy` is high for a single clock cycle per result and rises only for a delivered result.
- R3: With `settled_mode`=1 latched, the first 68 conversions after a sync are withheld. The first strobe comes 69 periods after the sync edge, and no delivered result is ever tagged 2'b01.
- R4: With `settled_mode`=0 latched, the first strobe comes one period after the sync edge. Each of the first 68 results carries tag 2'b01, and later results carry 2'b00 unless R5 applies.
- R5: A `step_det` pulse outside a sync cycle marks the next 69 conversions as partially settled, with tag 2'b10. Tag 2'b01 has priority over 2'b10. Withheld conversions also count down this window. A step sampled together with a sync is ignored.
- R6: A sync pulse restarts the period timing, the settling count and the step window from zero, even in the middle of a window. The first strobe after it follows the R3/R4 delay measured from the new sync edge.
- R7: Changes on `osr_sel` or `settled_mode` between sync pulses have no effect on the period, the strobe timing or the tags until the next sync.
- R8: `data_valid` goes low on a sync and rises with the first delivered strobe after it. It then stays high until the next sync.
- R9: While reset is held, `drdy`, `data_valid` and `result_tag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Modulator clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| osr_sel | input | 3 | Oversampling-ratio code, latched on sync |
| settled_mode | input | 1 | 1 withholds unsettled results, 0 delivers them tagged; latched on sync |
| sync_pulse | input | 1 | Restarts timing and settling count |
| step_det | input | 1 | Marks an asynchronous input step |
| drdy | output | 1 | One-cycle strobe for each delivered result |
| data_valid | output | 1 | High once a result has been delivered since the last sync |
| result_tag | output | 2 | Settling status of the most recent delivered result |

## Verification
The bench runs sync windows at short, medium and the longest ratio, in both modes. Each window pairs a step that falls inside the discard window with one that falls after it, which tells apart how the withhold count and the step count run. One run issues a sync in the middle of an unsettled window, and another issues a sync together with a step. These separate a true restart from a counter that merely continues. A run that changes the ratio and the mode between syncs shows whether the block samples these inputs only on a sync. Randomly placed syncs and steps with random ratios and modes are compared cycle by cycle against a model built from the requirements.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    TAG_SETTLED   = 2'b00,
    TAG_UNSETTLED = 2'b01,
    TAG_PARTIAL   = 2'b10
  } tag_e;

  // terminal count of the period counter for ratio code c: 2^(base+c) - 1
  function automatic int unsigned period_last(input int unsigned code,
                                              input int unsigned base_log2);
    return (32'd1 << (base_log2 + code)) - 32'd1;
  endfunction

endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dsc_period_timer.sv
module dsc_period_timer #(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned BASE_LOG2 = 5,
  parameter int unsigned LEN_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic [CODE_W-1:0] osr_sel,
  output logic              conv_done
);
  logic [CODE_W-1:0] code_q, code_d;
  logic [LEN_W-1:0]  ctr_q, ctr_d, last_cnt;
  logic              at_end;

  assign last_cnt  = LEN_W'(dsc_pkg::period_last(int'(code_q), BASE_LOG2));
  assign at_end    = (ctr_q == last_cnt);
  assign conv_done = at_end && !sync;

  always_comb begin
    code_d = code_q;
    ctr_d  = ctr_q;
    if (sync) begin
      code_d = osr_sel;
      ctr_d  = '0;
    end else if (at_end) begin
      ctr_d  = '0;
    end else begin
      ctr_d  = ctr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ctr_q  <= '0;
    end else begin
      code_q <= code_d;
      ctr_q  <= ctr_d;
    end
  end

  // R1: the phase counter never passes the terminal count of the latched ratio
  assert_ctr_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_q <= last_cnt);
  // R7: the latched ratio changes only on a sync
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(code_q));
endmodule

// File: rtl/dsc_settle_track.sv
module dsc_settle_track #(
  parameter int unsigned SETTLE_N = 68,
  parameter int unsigned PART_N   = 69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync,
  input  logic       mode_in,
  input  logic       step,
  input  logic       conv_done,
  output logic       deliver,
  output logic [1:0] tag_now,
  output logic       mode_q
);
  localparam int unsigned CW = $clog2(SETTLE_N + 1);
  localparam int unsigned PW = $clog2(PART_N + 1);
  localparam logic [CW-1:0] SETTLE_CNT = CW'(SETTLE_N);
  localparam logic [PW-1:0] PART_CNT   = PW'(PART_N);

  logic          mode_d;
  logic [CW-1:0] conv_q, conv_d;
  logic [PW-1:0] part_q, part_d;
  logic          settled;

  assign settled = (conv_q == SETTLE_CNT);
  assign deliver = conv_done && (!mode_q || settled);

  always_comb begin
    if (!settled)          tag_now = dsc_pkg::TAG_UNSETTLED;
    else if (part_q != '0) tag_now = dsc_pkg::TAG_PARTIAL;
    else                   tag_now = dsc_pkg::TAG_SETTLED;
  end

  always_comb begin
    mode_d = mode_q;
    conv_d = conv_q;
    part_d = part_q;
    if (sync) begin
      mode_d = mode_in;
      conv_d = '0;
      part_d = '0;
    end else begin
      if (conv_done && !settled)
        conv_d = conv_q + 1'b1;
      if (step)
        part_d = PART_CNT;
      else if (conv_done && part_q != '0)
        part_d = part_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      conv_q <= '0;
      part_q <= '0;
    end else begin
      mode_q <= mode_d;
      conv_q <= conv_d;
      part_q <= part_d;
    end
  end

  // R3: the settling count saturates at the settling length
  assert_conv_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q <= SETTLE_CNT);
  // R5: the partial window never exceeds its length
  assert_part_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    part_q <= PART_CNT);
  // R7: the latched mode changes only on a sync
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(mode_q));
endmodule

// File: rtl/dec_settle_ctrl.sv
module dec_settle_ctrl #(
  parameter int unsigned CODE_W    = 3,
  parameter int unsigned BASE_LOG2 = 5,
  parameter int unsigned SETTLE_N  = 68,
  parameter int unsigned PART_N    = 69
) (
  input  logic              mclk,
  input  logic              arst_n,
  input  logic [CODE_W-1:0] osr_sel,
  input  logic              settled_mode,
  input  logic              sync_pulse,
  input  logic              step_det,
  output logic              drdy,
  output logic              data_valid,
  output logic [1:0]        result_tag
);
  localparam int unsigned LEN_W = BASE_LOG2 + (1 << CODE_W) - 1;

  logic       rst_s;
  logic       conv_done, deliver, mode_lat;
  logic [1:0] tag_now;
  logic       drdy_d, valid_d;
  logic [1:0] tag_d;

  dsc_rst_sync #(.STAGES(2)) u_rst (
    .clk(mclk), .arst_n(arst_n), .rst_n_sync(rst_s)
  );

  dsc_period_timer #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2), .LEN_W(LEN_W)) u_timer (
    .clk(mclk), .rst_n(rst_s), .sync(sync_pulse), .osr_sel(osr_sel),
    .conv_done(conv_done)
  );

  dsc_settle_track #(.SETTLE_N(SETTLE_N), .PART_N(PART_N)) u_track (
    .clk(mclk), .rst_n(rst_s), .sync(sync_pulse), .mode_in(settled_mode),
    .step(step_det), .conv_done(conv_done), .deliver(deliver),
    .tag_now(tag_now), .mode_q(mode_lat)
  );

  always_comb begin
    drdy_d  = deliver;
    tag_d   = deliver ? tag_now : result_tag;
    valid_d = sync_pulse ? 1'b0 : (deliver ? 1'b1 : data_valid);
  end

  always_ff @(posedge mclk or negedge rst_s) begin
    if (!rst_s) begin
      drdy       <= 1'b0;
      data_valid <= 1'b0;
      result_tag <= dsc_pkg::TAG_SETTLED;
    end else begin
      drdy       <= drdy_d;
      data_valid <= valid_d;
      result_tag <= tag_d;
    end
  end

  // R2: strobe never lasts two cycles
  assert_drdy_single_R2: assert property (@(posedge mclk) disable iff (!rst_s)
    drdy |=> !drdy);
  // R8: a strobe always comes with the valid flag
  assert_valid_with_drdy_R8: assert property (@(posedge mclk) disable iff (!rst_s)
    drdy |-> data_valid);
  // R6: a sync clears strobe and valid on the next cycle
  assert_sync_clears_R6: assert property (@(posedge mclk) disable iff (!rst_s)
    sync_pulse |=> (!drdy && !data_valid));
  // R3: settled mode never delivers an unsettled tag
  assert_no_unsettled_out_R3: assert property (@(posedge mclk) disable iff (!rst_s)
    (drdy && mode_lat) |-> (result_tag != 2'b01));
endmodule

// File: tb/tb_dec_settle_ctrl.sv
module tb_dec_settle_ctrl;
  localparam time HALF = 2.5ns;
  localparam int  SET_N = 68;
  localparam int  PAR_N = 69;

  logic       mclk = 1'b0;
  logic       arst_n;
  logic [2:0] osr_sel;
  logic       settled_mode, sync_pulse, step_det;
  logic       drdy, data_valid;
  logic [1:0] result_tag;

  int vectors = 0;
  int fails   = 0;

  always #HALF mclk = ~mclk;

  dec_settle_ctrl dut (
    .mclk(mclk), .arst_n(arst_n), .osr_sel(osr_sel), .settled_mode(settled_mode),
    .sync_pulse(sync_pulse), .step_det(step_det), .drdy(drdy),
    .data_valid(data_valid), .result_tag(result_tag)
  );

  // reference model of the requirements
  bit      synced = 0;
  int      cyc = 0, sync_cyc = 0, last_drdy = -1, exp_first = 0;
  bit      first_seen = 0;
  int      m_osr = 32, m_ctr = 0, m_conv = 0, m_part = 0;
  bit      m_mode = 1, m_drdy = 0, m_valid = 0;
  logic [1:0] m_tag = 2'b00;
  string   lbl_first = "R3";
  string   lbl_period = "R1";

  function automatic int osr_of(input int code);
    return 32 << code;
  endfunction

  function automatic logic [1:0] tag_for(input int conv, input int part);
    if (conv < SET_N) return 2'b01;
    if (part > 0)     return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge mclk) begin
    cyc++;
    if (arst_n && sync_pulse) begin
      synced     = 1;
      m_osr      = osr_of(int'(osr_sel));
      m_mode     = settled_mode;
      m_ctr      = 0;
      m_conv     = 0;
      m_part     = 0;
      m_drdy     = 0;
      m_valid    = 0;
      sync_cyc   = cyc;
      first_seen = 0;
      last_drdy  = -1;
      exp_first  = m_mode ? (SET_N + 1) * m_osr : m_osr;
    end else if (synced) begin
      bit ev;
      ev     = (m_ctr == m_osr - 1);
      m_ctr  = ev ? 0 : m_ctr + 1;
      m_drdy = 0;
      if (ev) begin
        if (!m_mode || m_conv >= SET_N) begin
          m_drdy  = 1;
          m_valid = 1;
          m_tag   = tag_for(m_conv, m_part);
        end
        if (m_conv < SET_N) m_conv++;
      end
      if (step_det) m_part = PAR_N;
      else if (ev && m_part > 0) m_part--;
    end
  end

  always @(negedge mclk) begin
    if (arst_n && synced) begin
      check("R2", int'(drdy), int'(m_drdy));
      check("R8", int'(data_valid), int'(m_valid));
      if (drdy && m_drdy) begin
        if (m_tag == 2'b10)      check("R5", int'(result_tag), int'(m_tag));
        else if (m_tag == 2'b01) check("R4", int'(result_tag), int'(m_tag));
        else                     check(m_mode ? "R3" : "R4", int'(result_tag), int'(m_tag));
      end
      if (drdy) begin
        if (!first_seen) begin
          check(lbl_first, cyc - sync_cyc, exp_first);
          first_seen = 1;
        end else if (last_drdy >= 0) begin
          check(lbl_period, cyc - last_drdy, m_osr);
        end
        last_drdy = cyc;
      end
    end
  end

  task automatic tick();
    @(negedge mclk);
  endtask

  // one sync window: sync with code/mode, run len cycles, optional step and input change
  task automatic window(input int code, input bit mode, input int len,
                        input int step_at, input int chg_at,
                        input bit step_with_sync);
    tick();
    osr_sel      = 3'(code);
    settled_mode = mode;
    sync_pulse   = 1'b1;
    step_det     = step_with_sync;
    lbl_first    = mode ? "R3" : "R4";
    tick();
    sync_pulse = 1'b0;
    step_det   = 1'b0;
    for (int i = 0; i < len; i++) begin
      step_det = (i == step_at);
      if (i == chg_at) begin
        osr_sel      = 3'd3;
        settled_mode = ~mode;
        lbl_period   = "R7";
        lbl_first    = "R7";
      end
      tick();
    end
    step_det   = 1'b0;
    lbl_period = "R1";
  endtask

  initial begin
    #(HALF * 2 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seed;
    seed         = 7;
    void'($urandom(seed));
    arst_n       = 1'b0;
    osr_sel      = 3'd0;
    settled_mode = 1'b0;
    sync_pulse   = 1'b0;
    step_det     = 1'b0;
    repeat (4) tick();
    // R9: reset state
    check("R9", int'(drdy), 0);
    check("R9", int'(data_valid), 0);
    check("R9", int'(result_tag), 0);
    tick();
    arst_n = 1'b1;
    repeat (10) tick();

    window(0, 0, 3000, 500, -1, 0);     // R4 with step inside unsettled span (R5)
    window(0, 1, 3600, 1000, -1, 0);    // R3 with step inside discard window
    window(1, 1, 5200, 4500, -1, 0);    // R3 at ratio 64, step after settling
    lbl_first = "R6";
    window(0, 0, 700, -1, -1, 0);       // cut short by the next sync
    window(0, 1, 2600, -1, -1, 1);      // R6 restart mid-window; R5 step with sync ignored
    window(0, 1, 3000, 2700, 100, 0);   // R7 inputs change without sync
    window(2, 0, 2000, 300, -1, 0);     // ratio 128
    window(7, 0, 9000, -1, -1, 0);      // R1 longest ratio 4096
    for (int k = 0; k < 15; k++) begin
      int c, l, s;
      c = $urandom % 3;
      l = 300 + ($urandom % 3000);
      s = ($urandom % 2) ? int'($urandom % l) : -1;
      window(c, 1'($urandom % 2), l, s, -1, 0);
    end
    repeat (5) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule